// File: doc/BRIEF.md
# BERT Error Injection Unit

This block sits between a test-pattern generator and the line side of a bit error rate tester. It deliberately corrupts the outgoing pattern so that the far-end checker, and the link between the two, can be exercised against a known error rate. Each valid word from the generator passes through with one cycle of latency. When an error is due, bit 0 of that word is inverted and an inject flag is raised alongside it.

Errors come from two sources. The first is a rate counter that counts transmitted bits and fires once every 10^N bits, where N comes from a three-bit rate code. The second is a one-shot command that fires on a rising edge of a control input. The stream runs one, four or eight bits per word. In the word modes the fastest code cannot be met exactly, so it falls back to one error every eight bits.

When the pattern is a quasi-random signal that must never carry more than 14 zeros in a row, the block tracks the current zero run. It defers any inversion that would break this limit to the next valid word.

Top module: `bert_err_inj`

## Requirements
- R1: While rst_n is low, dat_o, vld_o and inj_o are all zero.
- R2: Each cycle the outputs register the inputs: vld_o equals the previous vld_i, and dat_o equals the previous dat_i except for an inverted bit 0 when an error was placed.
- R3: mode_i 00 selects serial (one bit per word, bit 0), 01 selects nibble (bits 3:0) and 10 selects byte (bits 7:0). Bits go out from bit 0 upward. Code 11 is invalid: no error is placed, no bits are counted and pending requests are kept.
- R4: rate_i 000 disables rate errors. A code N of 1 to 7 places one error each 10^N bits. A valid word adds its bit count to a running count. The error lands on the word in which the count reaches the period, and any excess carries over.
- R5: In nibble or byte mode with rate_i 001, the period is 8 bits: every second nibble word, or every byte word.
- R6: A 0-to-1 transition of sbe_i places exactly one error, on the first valid word in a later cycle. Holding sbe_i high places no further errors.
- R7: A pending one-shot error that meets a rate error on the same word is held and placed on a later word, so that the two never cancel.
- R8: With qrss_i high, an error that would turn bit 0 from 1 to 0 is deferred to the next valid word if the resulting zero run would exceed 14. That run counts the zeros already sent in a row, plus that bit, plus the zeros directly above it in the word's active bits. A deferred error is retried on each later word.
- R9: A change of rate_i or mode_i clears the bit count and any deferred rate error. That word counts no bits.
- R10: inj_o is high exactly when the word on dat_o had a bit inverted, and only together with vld_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dat_i | input | 8 | Pattern word, first bit in bit 0 |
| vld_i | input | 1 | Word valid strobe |
| mode_i | input | 2 | Word size select |
| rate_i | input | 3 | Error rate code |
| sbe_i | input | 1 | One-shot error command, edge sensitive |
| qrss_i | input | 1 | Enables zero-run protection |
| dat_o | output | 8 | Word with errors applied |
| vld_o | output | 1 | Output word valid |
| inj_o | output | 1 | Error placed in this word |

## Verification
The hardest case to reach is a deferral under zero-run protection. It needs a due error, a 1 in bit 0 and a long zero run, all on the same word. The random phases with the protection flag set drive words that are almost all zero, with sparse ones in bit 0, so that the run often stands near the limit when the rate counter fires. A second hard case is a one-shot request meeting a rate error. The fastest serial rate with frequent toggles of the command makes that collision occur repeatedly.

// File: rtl/bei_pkg.sv
package bei_pkg;
  typedef enum logic [1:0] {
    MD_SER  = 2'b00,
    MD_NIB  = 2'b01,
    MD_BYTE = 2'b10,
    MD_BAD  = 2'b11
  } mode_e;

  // Active bits per word for a mode; zero for the invalid code.
  function automatic int unsigned lane_bits(logic [1:0] m);
    case (m)
      MD_SER:  return 1;
      MD_NIB:  return 4;
      MD_BYTE: return 8;
      default: return 0;
    endcase
  endfunction

  // Bits between errors: 10^code, with the word-mode floor of 8.
  function automatic int unsigned err_period(logic [2:0] r, logic [1:0] m);
    int unsigned p;
    p = 1;
    for (int k = 1; k <= 7; k++)
      if (k <= int'(r)) p = p * 10;
    if (r == 3'd1 && m != MD_SER) p = 8;
    return p;
  endfunction
endpackage

// File: rtl/bei_rate_gen.sv
module bei_rate_gen #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  input  logic [3:0]    step,
  input  logic [CW-1:0] limit,
  output logic          hit
);
  logic [CW-1:0] cnt_q, cnt_nx;
  logic [CW:0]   sum;

  always_comb begin
    sum    = {1'b0, cnt_q} + (CW+1)'(step);
    hit    = en && (sum >= {1'b0, limit});
    cnt_nx = cnt_q;
    if (clr)      cnt_nx = '0;
    else if (hit) cnt_nx = CW'(sum - {1'b0, limit});
    else if (en)  cnt_nx = CW'(sum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end
endmodule

// File: rtl/bei_sbe_edge.sv
module bei_sbe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sbe_i,
  input  logic take,
  output logic pend
);
  logic sbe_q, pend_nx, rise;

  always_comb begin
    rise    = sbe_i & ~sbe_q;
    pend_nx = rise | (pend & ~take);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sbe_q <= 1'b0;
      pend  <= 1'b0;
    end else begin
      sbe_q <= sbe_i;
      pend  <= pend_nx;
    end
  end
endmodule

// File: rtl/bei_zero_guard.sv
module bei_zero_guard #(
  parameter int DW    = 8,
  parameter int LIMIT = 14,
  parameter int ZW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] data,
  input  logic [DW-1:0] sent,
  input  logic [3:0]    nbits,
  input  logic          qrss,
  input  logic          upd,
  output logic          brk
);
  localparam int ZMAX = (1 << ZW) - 1;

  logic [ZW-1:0] zrun_q, zrun_nx;
  int nb, za, run, z;
  logic open_run;

  always_comb begin
    nb       = int'(nbits);
    za       = 0;
    open_run = 1'b1;
    for (int i = 1; i < DW; i++) begin
      if (i < nb && open_run) begin
        if (!data[i]) za = za + 1;
        else          open_run = 1'b0;
      end
    end
    run = int'(zrun_q) + 1 + za;
    brk = qrss && data[0] && (run > LIMIT);

    z = int'(zrun_q);
    for (int i = 0; i < DW; i++) begin
      if (i < nb) begin
        if (sent[i])       z = 0;
        else if (z < ZMAX) z = z + 1;
      end
    end
    zrun_nx = upd ? ZW'(z) : zrun_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) zrun_q <= '0;
    else        zrun_q <= zrun_nx;
  end
endmodule

// File: rtl/bert_err_inj.sv
module bert_err_inj
  import bei_pkg::*;
#(
  parameter int DW        = 8,
  parameter int CW        = 24,
  parameter int ZERO_LIM  = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] dat_i,
  input  logic          vld_i,
  input  logic [1:0]    mode_i,
  input  logic [2:0]    rate_i,
  input  logic          sbe_i,
  input  logic          qrss_i,
  output logic [DW-1:0] dat_o,
  output logic          vld_o,
  output logic          inj_o
);
  logic [2:0]    rate_q;
  logic [1:0]    mode_q;
  logic          rpend_q, rpend_nx;
  logic          mode_ok, chg, go, rate_en, hit, brk;
  logic          rate_req, rate_inj, sbe_pend, sbe_take, inv;
  logic [3:0]    step;
  logic [CW-1:0] limit;
  logic [DW-1:0] word;

  always_comb begin
    mode_ok  = (mode_i != MD_BAD);
    chg      = (rate_i != rate_q) || (mode_i != mode_q);
    step     = 4'(lane_bits(mode_i));
    limit    = CW'(err_period(rate_i, mode_i));
    go       = vld_i && mode_ok;
    rate_en  = go && !chg && (rate_i != 3'd0);
    rate_req = go && !chg && (hit || rpend_q);
    rate_inj = rate_req && !brk;
    sbe_take = go && sbe_pend && !rate_req && !brk;
    inv      = rate_inj || sbe_take;
    word     = dat_i ^ {{(DW-1){1'b0}}, inv};
    rpend_nx = rpend_q;
    if (chg)                  rpend_nx = 1'b0;
    else if (rate_req && brk) rpend_nx = 1'b1;
    else if (rate_inj)        rpend_nx = 1'b0;
  end

  bei_rate_gen #(.CW(CW)) u_rate (
    .clk(clk), .rst_n(rst_n), .en(rate_en), .clr(chg),
    .step(step), .limit(limit), .hit(hit)
  );

  bei_sbe_edge u_sbe (
    .clk(clk), .rst_n(rst_n), .sbe_i(sbe_i), .take(sbe_take), .pend(sbe_pend)
  );

  bei_zero_guard #(.DW(DW), .LIMIT(ZERO_LIM)) u_zg (
    .clk(clk), .rst_n(rst_n), .data(dat_i), .sent(word), .nbits(step),
    .qrss(qrss_i), .upd(go), .brk(brk)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_o   <= '0;
      vld_o   <= 1'b0;
      inj_o   <= 1'b0;
      rate_q  <= '0;
      mode_q  <= '0;
      rpend_q <= 1'b0;
    end else begin
      dat_o   <= word;
      vld_o   <= vld_i;
      inj_o   <= inv;
      rate_q  <= rate_i;
      mode_q  <= mode_i;
      rpend_q <= rpend_nx;
    end
  end
endmodule

// File: rtl/bert_err_inj_chk.sv
module bert_err_inj_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] dat_i,
  input logic          vld_i,
  input logic [1:0]    mode_i,
  input logic [DW-1:0] dat_o,
  input logic          vld_o,
  input logic          inj_o
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  // R10
  inj_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inj_o |-> vld_o);
  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> vld_o == $past(vld_i));
  // R2
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !inj_o) |-> dat_o == $past(dat_i));
  // R10
  one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && inj_o) |-> dat_o == ($past(dat_i) ^ DW'(1)));
  // R3
  bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(mode_i) == 2'b11) |-> !inj_o);
endmodule

bind bert_err_inj bert_err_inj_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dat_i(dat_i), .vld_i(vld_i), .mode_i(mode_i),
  .dat_o(dat_o), .vld_o(vld_o), .inj_o(inj_o)
);

// File: tb/bert_err_inj_tb.sv
module bert_err_inj_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] dat_i;
  logic       vld_i, sbe_i, qrss_i;
  logic [1:0] mode_i;
  logic [2:0] rate_i;
  logic [7:0] dat_o;
  logic       vld_o, inj_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  bert_err_inj u_dut (
    .clk(clk), .rst_n(rst_n), .dat_i(dat_i), .vld_i(vld_i), .mode_i(mode_i),
    .rate_i(rate_i), .sbe_i(sbe_i), .qrss_i(qrss_i),
    .dat_o(dat_o), .vld_o(vld_o), .inj_o(inj_o)
  );

  // model state
  longint m_cnt;
  bit     m_rp, m_sp, m_sq;
  int     m_z;
  bit [2:0] m_rq;
  bit [1:0] m_mq;
  bit [7:0] e_dat;
  bit       e_vld, e_inj;
  string    e_tag;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic longint period_of(bit [2:0] r, bit [1:0] m);
    longint p = 1;
    for (int k = 1; k <= int'(r); k++) p = p * 10;
    if (r == 1 && m != 2'b00) p = 8;
    return p;
  endfunction

  task automatic model(bit [7:0] d, bit v, bit [1:0] md, bit [2:0] rt, bit s, bit q);
    int w, za, z;
    longint p, nx, cnt_n;
    bit ok, chg, go, hit, brk, req, rinj, stk, open_run, rp_n, sp_n;
    bit [7:0] o;
    w   = (md == 0) ? 1 : (md == 1) ? 4 : (md == 2) ? 8 : 0;
    p   = period_of(rt, md);
    ok  = (md != 3);
    chg = (rt != m_rq) || (md != m_mq);
    go  = v && ok;
    hit = 0;
    cnt_n = m_cnt;
    if (go && !chg && rt != 0) begin
      nx = m_cnt + w;
      if (nx >= p) begin hit = 1; cnt_n = nx - p; end
      else cnt_n = nx;
    end
    if (chg) cnt_n = 0;
    za = 0; open_run = 1;
    for (int i = 1; i < w; i++)
      if (open_run) begin
        if (!d[i]) za++; else open_run = 0;
      end
    brk  = q && d[0] && (m_z + 1 + za > 14);
    req  = go && !chg && (hit || m_rp);
    rinj = req && !brk;
    stk  = go && m_sp && !req && !brk;
    if (!ok)                               e_tag = "R3";
    else if (go && brk && (req || m_sp))   e_tag = "R8";
    else if (go && m_sp && req)            e_tag = "R7";
    else if (stk)                          e_tag = "R6";
    else if (rinj && rt == 1 && w > 1)     e_tag = "R5";
    else if (rinj)                         e_tag = "R4";
    else if (chg)                          e_tag = "R9";
    else                                   e_tag = "R2";
    o = d ^ {7'b0, (rinj || stk)};
    if (go) begin
      z = m_z;
      for (int i = 0; i < w; i++)
        if (o[i]) z = 0; else if (z < 31) z++;
      m_z = z;
    end
    rp_n = m_rp;
    if (chg)              rp_n = 0;
    else if (req && brk)  rp_n = 1;
    else if (rinj)        rp_n = 0;
    sp_n = (s && !m_sq) || (m_sp && !stk);
    m_cnt = cnt_n; m_rp = rp_n; m_sp = sp_n; m_sq = s; m_rq = rt; m_mq = md;
    e_dat = o; e_vld = v; e_inj = rinj || stk;
  endtask

  task automatic run_phase(bit [1:0] md, bit [2:0] rt, bit q, int n, int sbe_pct);
    bit [7:0] d;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      chk(dat_o == e_dat, e_tag, "dat_o", dat_o, e_dat);
      chk(vld_o == e_vld, "R2", "vld_o", vld_o, e_vld);
      chk(inj_o == e_inj, "R10", "inj_o", inj_o, e_inj);
      if (!q) d = 8'($urandom);
      else if (md == 0) d = {7'($urandom), ($urandom % 20 == 0)};
      else d = {(($urandom % 6 == 0) ? 7'($urandom) : 7'd0), ($urandom % 4 == 0)};
      if (int'($urandom % 100) < sbe_pct) sbe_i = ~sbe_i;
      dat_i = d; vld_i = ($urandom % 5 != 0); mode_i = md; rate_i = rt; qrss_i = q;
      model(dat_i, vld_i, mode_i, rate_i, sbe_i, qrss_i);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 0; dat_i = 0; vld_i = 0; mode_i = 0; rate_i = 0; sbe_i = 0; qrss_i = 0;
    m_cnt = 0; m_rp = 0; m_sp = 0; m_sq = 0; m_z = 0; m_rq = 0; m_mq = 0;
    e_dat = 0; e_vld = 0; e_inj = 0; e_tag = "R2";
    repeat (3) @(negedge clk);
    chk(dat_o == 0, "R1", "reset dat_o", dat_o, 0);
    chk(vld_o == 0, "R1", "reset vld_o", vld_o, 0);
    chk(inj_o == 0, "R1", "reset inj_o", inj_o, 0);
    rst_n = 1;
    run_phase(2'b00, 3'd1, 0, 2000, 5);
    run_phase(2'b00, 3'd2, 0, 1500, 2);
    run_phase(2'b01, 3'd1, 0, 1500, 2);
    run_phase(2'b10, 3'd1, 0, 1500, 2);
    run_phase(2'b10, 3'd2, 0, 1500, 2);
    run_phase(2'b01, 3'd3, 0, 2000, 1);
    run_phase(2'b11, 3'd1, 0, 800, 3);
    run_phase(2'b00, 3'd0, 0, 800, 3);
    run_phase(2'b00, 3'd1, 1, 3000, 2);
    run_phase(2'b01, 3'd1, 1, 2000, 3);
    run_phase(2'b10, 3'd2, 1, 2000, 3);
    run_phase(2'b10, 3'd1, 1, 2000, 3);
    @(negedge clk);
    chk(dat_o == e_dat, e_tag, "dat_o", dat_o, e_dat);
    chk(inj_o == e_inj, "R10", "inj_o", inj_o, e_inj);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        #5_000_000;
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule